// File: doc/BRIEF.md
# Split-Converter Upset-Tolerant Output Combiner

This block is the digital back end of a two-stage pipelined successive-approximation converter. The converter is built as two identical halves that sample the same input. Each half supplies three things per sample: a 9-bit coarse code, a 7-bit fine code, and an upset flag raised by an analog charge-hit detector. The block turns each half's two codes into one value. The stages overlap by two redundant bits, so the coarse code is weighted by 32 and the fine code is added with a mid-scale offset of 16 removed. The block also flags a fine code that saturates at either end, since that means the coarse stage went out of range.

Each sample, the combiner decides which of the two half values to trust. When both halves look healthy, it outputs their sum. The sum is the average carried with one extra fractional bit, which gains about 3 dB of SNR. When exactly one half was disturbed, it outputs the other half, shifted into the same format. A status bit reports a double fault. Another status bit reports a difference between two clean halves that exceeds a programmable threshold. The result is registered together with its own valid strobe, one cycle after the input strobe.

Top module: `split_see_combiner`

## Requirements
- R1: A half's value is coarse*32 + fine - 16, as a signed number. The output word carries one fractional bit, so a single half H appears on `out_word` as 2*H.
- R2: A fine code of all ones (127) or all zeros (0) sets the out-of-range bit of that half (`out_rng_a` / `out_rng_b`) for that sample.
- R3: A half is treated as disturbed if its upset flag is high or its fine code is out of range.
- R4: When neither half is disturbed, `out_word` = A + B and `out_mode` = 00 (average).
- R5: When only half A is disturbed, `out_word` = 2*B and `out_mode` = 10. When only half B is disturbed, `out_word` = 2*A and `out_mode` = 01. In both cases `out_dbl` and `out_mis` are 0. Mode 11 never occurs.
- R6: When both halves are disturbed, `out_word` = A + B, `out_mode` = 00 and `out_dbl` = 1.
- R7: When neither half is disturbed and |A - B| is strictly greater than `diff_thr`, `out_mis` = 1 and the average is still output. At |A - B| = `diff_thr`, `out_mis` = 0.
- R8: `out_vld` is high in exactly the cycle after a cycle with `in_vld` high, and the result belongs to that input sample.
- R9: Synchronous active-high `rst` clears `out_vld`, `out_word`, `out_mode` and every status bit.
- R10: An upset flag affects only the sample it arrives with. The next clean sample is averaged normally.
- R11: While `in_vld` is low, `out_word`, `out_mode` and the status bits hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | One strobe per input sample |
| a_crs | input | 9 | Half A coarse-stage code |
| a_fin | input | 7 | Half A fine-stage code |
| a_hit | input | 1 | Half A upset flag for this sample |
| b_crs | input | 9 | Half B coarse-stage code |
| b_fin | input | 7 | Half B fine-stage code |
| b_hit | input | 1 | Half B upset flag for this sample |
| diff_thr | input | 16 | Mismatch threshold on \|A - B\| |
| out_vld | output | 1 | Output strobe |
| out_word | output | 17 | Signed result with one fractional bit |
| out_mode | output | 2 | 00 average, 01 half A alone, 10 half B alone |
| out_rng_a | output | 1 | Half A fine code saturated |
| out_rng_b | output | 1 | Half B fine code saturated |
| out_dbl | output | 1 | Both halves disturbed |
| out_mis | output | 1 | Clean halves differ beyond threshold |

## Verification
Fixed codes at the lowest and highest ends of the code range check the shift-and-add merge and its sign. Saturated fine codes are applied to each half with the upset flag held low, which shows that the range check alone can steer the selection. Pairs of halves whose difference equals the threshold, and exceeds it by one, pin down the comparison. A hit sample followed by a clean one, and an idle cycle with changed inputs, show that no state leaks between samples. A long random run mixes hits, saturations and wide mismatches, and each sample is compared against a behavioural model.

// File: rtl/split_see_pkg.sv
package split_see_pkg;

  typedef enum logic [1:0] {
    MODE_AVG  = 2'b00,
    MODE_A    = 2'b01,
    MODE_B    = 2'b10
  } mode_e;

  function automatic int half_width(input int crs_w, input int fin_w, input int red_w);
    return crs_w + fin_w - red_w + 2;
  endfunction

endpackage

// File: rtl/half_merge.sv
module half_merge #(
  parameter int CRS_W = 9,
  parameter int FIN_W = 7,
  parameter int RED_W = 2,
  parameter int HW    = split_see_pkg::half_width(CRS_W, FIN_W, RED_W)
) (
  input  logic [CRS_W-1:0]     crs,
  input  logic [FIN_W-1:0]     fin,
  input  logic                 hit,
  output logic signed [HW-1:0] val,
  output logic                 rng,
  output logic                 bad
);
  localparam int SHIFT = FIN_W - RED_W;

  localparam logic signed [HW-1:0] OFS_V = {{(HW-SHIFT){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}};

  logic signed [HW-1:0] up_part;
  logic signed [HW-1:0] lo_part;

  assign up_part = {{(HW-CRS_W-SHIFT){1'b0}}, crs, {SHIFT{1'b0}}};
  assign lo_part = {{(HW-FIN_W){1'b0}}, fin};
  assign val     = up_part + lo_part - OFS_V;

  assign rng = (fin == {FIN_W{1'b1}}) || (fin == {FIN_W{1'b0}});
  assign bad = hit | rng;

endmodule

// File: rtl/half_pick.sv
module half_pick
  import split_see_pkg::*;
#(
  parameter int HW = 16,
  parameter int OW = HW + 1
) (
  input  logic signed [HW-1:0] va,
  input  logic signed [HW-1:0] vb,
  input  logic                 bad_a,
  input  logic                 bad_b,
  input  logic [HW-1:0]        thr,
  output logic signed [OW-1:0] word,
  output mode_e                mode,
  output logic                 dbl,
  output logic                 mis
);
  logic signed [OW-1:0] ea;
  logic signed [OW-1:0] eb;
  logic signed [OW-1:0] sum;
  logic signed [OW-1:0] dif;
  logic        [OW-1:0] mag;
  logic                 wide;

  assign ea   = {va[HW-1], va};
  assign eb   = {vb[HW-1], vb};
  assign sum  = ea + eb;
  assign dif  = ea - eb;
  assign mag  = dif[OW-1] ? (-dif) : dif;
  assign wide = mag > {1'b0, thr};

  always_comb begin
    word = sum;
    mode = MODE_AVG;
    dbl  = 1'b0;
    mis  = 1'b0;
    unique case ({bad_a, bad_b})
      2'b00: mis = wide;
      2'b01: begin
        word = {va, 1'b0};
        mode = MODE_A;
      end
      2'b10: begin
        word = {vb, 1'b0};
        mode = MODE_B;
      end
      default: dbl = 1'b1;
    endcase
  end

endmodule

// File: rtl/split_see_combiner.sv
module split_see_combiner
  import split_see_pkg::*;
#(
  parameter int CRS_W = 9,
  parameter int FIN_W = 7,
  parameter int RED_W = 2,
  parameter int HW    = split_see_pkg::half_width(CRS_W, FIN_W, RED_W),
  parameter int OW    = HW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic [CRS_W-1:0]     a_crs,
  input  logic [FIN_W-1:0]     a_fin,
  input  logic                 a_hit,
  input  logic [CRS_W-1:0]     b_crs,
  input  logic [FIN_W-1:0]     b_fin,
  input  logic                 b_hit,
  input  logic [HW-1:0]        diff_thr,
  output logic                 out_vld,
  output logic signed [OW-1:0] out_word,
  output logic [1:0]           out_mode,
  output logic                 out_rng_a,
  output logic                 out_rng_b,
  output logic                 out_dbl,
  output logic                 out_mis
);
  localparam int NH = 2;

  logic [CRS_W-1:0]     crs_v [NH];
  logic [FIN_W-1:0]     fin_v [NH];
  logic                 hit_v [NH];
  logic signed [HW-1:0] val_v [NH];
  logic                 rng_v [NH];
  logic                 bad_v [NH];

  assign crs_v[0] = a_crs;
  assign crs_v[1] = b_crs;
  assign fin_v[0] = a_fin;
  assign fin_v[1] = b_fin;
  assign hit_v[0] = a_hit;
  assign hit_v[1] = b_hit;

  for (genvar g = 0; g < NH; g++) begin : g_half
    half_merge #(
      .CRS_W(CRS_W),
      .FIN_W(FIN_W),
      .RED_W(RED_W),
      .HW   (HW)
    ) i_merge (
      .crs(crs_v[g]),
      .fin(fin_v[g]),
      .hit(hit_v[g]),
      .val(val_v[g]),
      .rng(rng_v[g]),
      .bad(bad_v[g])
    );
  end

  logic signed [OW-1:0] nx_word;
  mode_e                nx_mode;
  logic                 nx_dbl;
  logic                 nx_mis;

  half_pick #(
    .HW(HW),
    .OW(OW)
  ) i_pick (
    .va   (val_v[0]),
    .vb   (val_v[1]),
    .bad_a(bad_v[0]),
    .bad_b(bad_v[1]),
    .thr  (diff_thr),
    .word (nx_word),
    .mode (nx_mode),
    .dbl  (nx_dbl),
    .mis  (nx_mis)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld   <= 1'b0;
      out_word  <= '0;
      out_mode  <= MODE_AVG;
      out_rng_a <= 1'b0;
      out_rng_b <= 1'b0;
      out_dbl   <= 1'b0;
      out_mis   <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_word  <= nx_word;
        out_mode  <= nx_mode;
        out_rng_a <= rng_v[0];
        out_rng_b <= rng_v[1];
        out_dbl   <= nx_dbl;
        out_mis   <= nx_mis;
      end
    end
  end

endmodule

// File: rtl/split_see_combiner_chk.sv
module split_see_combiner_chk #(
  parameter int CRS_W = 9,
  parameter int FIN_W = 7,
  parameter int OW    = 17
) (
  input logic             clk,
  input logic             rst,
  input logic             in_vld,
  input logic [FIN_W-1:0] a_fin,
  input logic             a_hit,
  input logic [FIN_W-1:0] b_fin,
  input logic             b_hit,
  input logic             out_vld,
  input logic [OW-1:0]    out_word,
  input logic [1:0]       out_mode,
  input logic             out_rng_a,
  input logic             out_dbl,
  input logic             out_mis
);
  logic b_in_range;
  assign b_in_range = (b_fin != {FIN_W{1'b1}}) && (b_fin != {FIN_W{1'b0}});

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_vld |=> out_vld); // R8
  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (rst) !in_vld |=> !out_vld); // R8
  AST_RANGE_FLAG: assert property (@(posedge clk) disable iff (rst)
    in_vld && ((a_fin == {FIN_W{1'b1}}) || (a_fin == {FIN_W{1'b0}})) |=> out_rng_a); // R2
  AST_ONLY_B: assert property (@(posedge clk) disable iff (rst)
    in_vld && a_hit && !b_hit && b_in_range |=> out_mode == 2'b10); // R5
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst) out_mode != 2'b11); // R5
  AST_SINGLE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    out_vld && out_mode != 2'b00 |-> !out_dbl && !out_mis); // R5
  AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst) !(out_dbl && out_mis)); // R6
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst) !in_vld |=> $stable(out_word)); // R11

endmodule

bind split_see_combiner split_see_combiner_chk #(
  .CRS_W(CRS_W),
  .FIN_W(FIN_W),
  .OW   (OW)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .in_vld   (in_vld),
  .a_fin    (a_fin),
  .a_hit    (a_hit),
  .b_fin    (b_fin),
  .b_hit    (b_hit),
  .out_vld  (out_vld),
  .out_word (out_word),
  .out_mode (out_mode),
  .out_rng_a(out_rng_a),
  .out_dbl  (out_dbl),
  .out_mis  (out_mis)
);

// File: tb/test_split_see_combiner.sv
`timescale 1ns/1ps
module test_split_see_combiner;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic [8:0] a_crs = '0, b_crs = '0;
  logic [6:0] a_fin = 7'd64, b_fin = 7'd64;
  logic a_hit = 1'b0, b_hit = 1'b0;
  logic [15:0] diff_thr = 16'hFFFF;
  logic out_vld;
  logic signed [16:0] out_word;
  logic [1:0] out_mode;
  logic out_rng_a, out_rng_b, out_dbl, out_mis;

  int n_run = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  split_see_combiner i_split_see_combiner (
    .clk(clk), .rst(rst), .in_vld(in_vld),
    .a_crs(a_crs), .a_fin(a_fin), .a_hit(a_hit),
    .b_crs(b_crs), .b_fin(b_fin), .b_hit(b_hit),
    .diff_thr(diff_thr), .out_vld(out_vld), .out_word(out_word),
    .out_mode(out_mode), .out_rng_a(out_rng_a), .out_rng_b(out_rng_b),
    .out_dbl(out_dbl), .out_mis(out_mis)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: expected results for one sample
  longint e_word;
  int e_mode;
  bit e_ra, e_rb, e_dbl, e_mis;

  function automatic void model(input int ac, input int af, input bit ah,
                                input int bc, input int bf, input bit bh, input int th);
    longint va, vb, d;
    bit da, db;
    va = ac * 32 + af - 16;
    vb = bc * 32 + bf - 16;
    e_ra = (af == 0) || (af == 127);
    e_rb = (bf == 0) || (bf == 127);
    da = ah || e_ra;
    db = bh || e_rb;
    d = (va > vb) ? va - vb : vb - va;
    e_dbl = da && db;
    e_mis = !da && !db && (d > th);
    if (da && !db) begin e_word = 2 * vb; e_mode = 2; end
    else if (db && !da) begin e_word = 2 * va; e_mode = 1; end
    else begin e_word = va + vb; e_mode = 0; end
  endfunction

  task automatic check_out(input string req);
    chk(req, "vld", out_vld, 1);
    chk(req, "word", out_word, e_word);
    chk(req, "mode", out_mode, e_mode);
    chk(req, "rng_a", out_rng_a, e_ra);
    chk(req, "rng_b", out_rng_b, e_rb);
    chk(req, "dbl", out_dbl, e_dbl);
    chk(req, "mis", out_mis, e_mis);
  endtask

  // Drive at falling edge, result registered at next rising edge, sample at next falling edge
  task automatic send(input int ac, input int af, input bit ah,
                      input int bc, input int bf, input bit bh, input int th, input string req);
    @(negedge clk);
    in_vld = 1'b1;
    a_crs = 9'(ac); a_fin = 7'(af); a_hit = ah;
    b_crs = 9'(bc); b_fin = 7'(bf); b_hit = bh;
    diff_thr = 16'(th);
    model(ac, af, ah, bc, bf, bh, th);
    @(negedge clk);
    in_vld = 1'b0;
    a_hit = 1'b0; b_hit = 1'b0;
    check_out(req);
  endtask

  task automatic check_cleared(input string req);
    chk(req, "vld", out_vld, 0);
    chk(req, "word", out_word, 0);
    chk(req, "mode", out_mode, 0);
    chk(req, "rng_a", out_rng_a, 0);
    chk(req, "rng_b", out_rng_b, 0);
    chk(req, "dbl", out_dbl, 0);
    chk(req, "mis", out_mis, 0);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_cleared("R9");
    rst = 1'b0;

    // R1: merge arithmetic seen through single-half selection
    send(0, 64, 1'b1, 100, 40, 1'b0, 65535, "R1");
    send(0, 64, 1'b1, 511, 126, 1'b0, 65535, "R1");
    send(0, 1, 1'b0, 7, 64, 1'b1, 65535, "R1");
    // R2/R3: saturation alone marks a half disturbed
    send(10, 127, 1'b0, 20, 50, 1'b0, 65535, "R2");
    send(10, 60, 1'b0, 20, 0, 1'b0, 65535, "R3");
    // R4: clean average
    send(200, 33, 1'b0, 201, 90, 1'b0, 65535, "R4");
    send(0, 1, 1'b0, 0, 1, 1'b0, 0, "R4");
    // R5: single hit on each side
    send(300, 70, 1'b0, 5, 5, 1'b1, 65535, "R5");
    send(300, 70, 1'b1, 5, 5, 1'b0, 65535, "R5");
    // R6: both disturbed, by flag and by saturation
    send(40, 40, 1'b1, 50, 50, 1'b1, 65535, "R6");
    send(40, 0, 1'b0, 50, 127, 1'b0, 65535, "R6");
    // R7: threshold boundary (A - B = 32 here)
    send(11, 64, 1'b0, 10, 64, 1'b0, 32, "R7");
    send(11, 64, 1'b0, 10, 64, 1'b0, 31, "R7");
    send(10, 64, 1'b0, 400, 64, 1'b0, 100, "R7");
    // R10: a hit does not carry into the next sample
    send(50, 50, 1'b1, 60, 60, 1'b0, 65535, "R10");
    send(50, 50, 1'b0, 60, 60, 1'b0, 65535, "R10");

    // R11 / R8: idle cycle with changed inputs holds the result
    @(negedge clk);
    a_crs = 9'd500; a_fin = 7'd0; a_hit = 1'b1; b_hit = 1'b1;
    @(negedge clk);
    chk("R8", "vld idle", out_vld, 0);
    chk("R11", "word hold", out_word, e_word);
    chk("R11", "mode hold", out_mode, e_mode);
    chk("R11", "rng_a hold", out_rng_a, e_ra);
    chk("R11", "dbl hold", out_dbl, e_dbl);
    a_hit = 1'b0; b_hit = 1'b0;

    // Random mix, compared against the model every sample
    for (int k = 0; k < 400; k++) begin
      int ac, af, bc, bf, th;
      bit ah, bh;
      ac = $urandom_range(0, 511);
      af = $urandom_range(1, 126);
      bc = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 511) : ac + $urandom_range(0, 2) - 1;
      if (bc < 0) bc = 0;
      if (bc > 511) bc = 511;
      bf = $urandom_range(1, 126);
      if ($urandom_range(0, 7) == 0) af = ($urandom_range(0, 1) == 1) ? 127 : 0;
      if ($urandom_range(0, 7) == 0) bf = ($urandom_range(0, 1) == 1) ? 127 : 0;
      ah = ($urandom_range(0, 4) == 0);
      bh = ($urandom_range(0, 4) == 0);
      th = $urandom_range(0, 300);
      send(ac, af, ah, bc, bf, bh, th, "R4/R5/R6/R7 random");
    end

    // R9: reset in mid-stream clears everything
    send(123, 45, 1'b0, 200, 99, 1'b1, 65535, "R5");
    @(negedge clk);
    rst = 1'b1;
    in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    check_cleared("R9");
    rst = 1'b0;
    send(1, 2, 1'b0, 1, 3, 1'b0, 65535, "R8");

    done = 1'b1;
    report();
  end

endmodule